// File: doc/BRIEF.md
# Single-Line Configurable Interrupt Controller

This block watches one external interrupt line and turns it into a masked interrupt request for a parent controller. Software picks one of four trigger senses: low level, high level, falling edge or rising edge. A detected event sets a sticky pending flag. Software clears that flag by writing a one to it. An enable bit gates the flag onto the registered output `irq_o`.

The external line is asynchronous. It passes through a synchroniser, and edges are found by comparing the synchronised value with its value one cycle earlier. Software reaches the block through a single-cycle register port with three registers: control, pending and enable. Read data is combinational in the cycle of the read. A build-time parameter places the enable register at one of two offsets.

In edge modes, software clears the flag when it accepts the interrupt. In level modes, it clears the flag after handling, once the source has let go of the line. Bring-up leaves the enable bit at 0 and writes 1 to the pending register to discard any stale event.

Top module: `line_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the trigger field, enable bit, pending flag and `irq_o` are all 0.
- R2: The control register is at offset 0x00, and its bits [1:0] hold the trigger code. The codes are 0 for low level, 1 for falling edge, 2 for high level and 3 for rising edge. A write stores only bits [1:0]. Bits above 1 always read 0.
- R3: In a level mode, the pending flag sets while the synchronised line is at the active level. A clear has no effect while the line stays active. After the line goes inactive, a clear drops the flag.
- R4: In an edge mode, only a transition in the selected direction sets the pending flag. A transition in the opposite direction leaves it unchanged.
- R5: The pending flag reads as bit 0 at offset 0x04. A write there with bit 0 = 1 clears the flag. A write there with bit 0 = 0 has no effect.
- R6: The enable bit is bit 0 of the register at offset 0x08 when `ENABLE_AT_ALT` = 0, and at offset 0x34 when it is 1. Writing 1 unmasks the interrupt and writing 0 masks it.
- R7: `irq_o` is a registered copy of (pending AND enable). Masking drops `irq_o` but keeps the pending flag.
- R8: With the enable bit at 1, the pending flag at 0 and a rising-edge trigger, a line change applied before a clock edge makes `irq_o` rise on the fourth rising edge that follows.
- R9: If a hardware set and a software clear of the pending flag occur in the same cycle, the flag ends at 1.
- R10: Reads of any other offset return 0, and writes to any other offset change nothing. `rdata_o` is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous external interrupt line |
| sel_i | input | 1 | Register access in this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Masked interrupt request to the parent controller |

## Verification
The assertions take for granted that the bus inputs are known and steady across each sampling edge, with at most one access per cycle. They also take for granted that every level on `line_i` lasts longer than one clock, so no pulse is lost inside the synchroniser. The stimulus drives every input on the falling clock edge. Outside the two exact-timing cases, it leaves at least six cycles between one change and the next, so both the synchroniser and the `irq_o` register settle before the bench compares against its own model.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HI    = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_e;

    // Synchronised line value and its value one cycle earlier.
    typedef struct packed {
        logic cur;
        logic prev;
    } line_samp_t;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_PEND  = 'h04;
    localparam int OFS_EN_A  = 'h08;
    localparam int OFS_EN_B  = 'h34;

    function automatic int enable_ofs(input int alt);
        return (alt != 0) ? OFS_EN_B : OFS_EN_A;
    endfunction

    // One when the selected trigger sense sees an event this cycle.
    function automatic logic trig_hit(input trig_e t, input line_samp_t s);
        logic hit;
        case (t)
            TRIG_LVL_LO:    hit = ~s.cur;
            TRIG_EDGE_FALL: hit = s.prev & ~s.cur;
            TRIG_LVL_HI:    hit = s.cur;
            default:        hit = ~s.prev & s.cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_i,
    output lirq_pkg::line_samp_t  samp_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[LAST];
    end

    assign samp_o.cur  = chain_q[LAST];
    assign samp_o.prev = prev_q;

    // prev follows cur one cycle later (supports edge detection, R4)
    assert_prev_follows_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (samp_o.prev == $past(samp_o.cur)));
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
    import lirq_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int ENABLE_AT_ALT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pend_i,
    output logic [DATA_W-1:0] rdata_o,
    output trig_e             trig_o,
    output logic              en_o,
    output logic              clr_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(enable_ofs(ENABLE_AT_ALT));

    logic  wr_ctrl, wr_pend, wr_en, rd;
    trig_e trig_q;
    logic  en_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:2];

    assign rd      = sel_i & ~wr_i;
    assign wr_ctrl = sel_i & wr_i & (addr_i == A_CTRL);
    assign wr_pend = sel_i & wr_i & (addr_i == A_PEND);
    assign wr_en   = sel_i & wr_i & (addr_i == A_EN);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= TRIG_LVL_LO;
            en_q   <= 1'b0;
        end else begin
            if (wr_ctrl) trig_q <= trig_e'(wdata_i[1:0]);
            if (wr_en)   en_q   <= wdata_i[0];
        end
    end

    assign clr_o  = wr_pend & wdata_i[0];
    assign trig_o = trig_q;
    assign en_o   = en_q;

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            if (addr_i == A_CTRL)      rdata_o[1:0] = trig_q;
            else if (addr_i == A_PEND) rdata_o[0]   = pend_i;
            else if (addr_i == A_EN)   rdata_o[0]   = en_q;
        end
    end

    assert_trig_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(sel_i && wr_i && addr_i == A_CTRL) |=> $stable(trig_q));
    assert_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(sel_i && wr_i && addr_i == A_EN) |=> $stable(en_q));
    assert_idle_read_R10: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (rdata_o == '0));
endmodule

// File: rtl/lirq_pend.sv
module lirq_pend
    import lirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_e      trig_i,
    input  line_samp_t samp_i,
    input  logic       clr_i,
    output logic       pend_o
);
    logic set_evt;
    logic pend_q;

    assign set_evt = trig_hit(trig_i, samp_i);

    // Hardware set has priority over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)          pend_q <= 1'b0;
        else if (set_evt) pend_q <= 1'b1;
        else if (clr_i)   pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> pend_q);
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_evt) |=> !pend_q);
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(set_evt));
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
    import lirq_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int ENABLE_AT_ALT = 0,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    line_samp_t samp_w;
    trig_e      trig_w;
    logic       en_w, clr_w, pend_w;
    logic       irq_q;

    lirq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .samp_o (samp_w)
    );

    lirq_regs #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .ENABLE_AT_ALT (ENABLE_AT_ALT)
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .pend_i  (pend_w),
        .rdata_o (rdata_o),
        .trig_o  (trig_w),
        .en_o    (en_w),
        .clr_o   (clr_w)
    );

    lirq_pend pend_i (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_w),
        .samp_i (samp_w),
        .clr_i  (clr_w),
        .pend_o (pend_w)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pend_w & en_w;
    end

    assign irq_o = irq_q;

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(pend_w & en_w)));
    assert_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (!en_w && !irq_o) |=> !irq_o);
endmodule

// File: tb/line_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module line_irq_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_CTRL = 8'h00;
    localparam logic [AW-1:0] A_PEND = 8'h04;
    localparam logic [AW-1:0] A_EN   = 8'h08;
    localparam logic [AW-1:0] A_ALT  = 8'h34;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line = 1'b1;
    logic          sel = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .line_i(line), .sel_i(sel), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #2 d = rdata;
        sel = 1'b0;
    endtask

    function automatic bit lvl_active(input int mode, input bit ln);
        if (mode == 0) return !ln;
        if (mode == 2) return ln;
        return 1'b0;
    endfunction

    function automatic bit edge_hit(input int mode, input bit o, input bit n);
        if (mode == 1) return o && !n;
        if (mode == 3) return !o && n;
        return 1'b0;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (R1..) actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        int  m_mode;
        bit  m_en, m_line, m_pend;
        void'($urandom(32'd20240611));

        // R1: state during reset
        wait_cyc(3);
        check("R1 irq in reset", {31'd0, irq}, 0);
        bus_read(A_CTRL, rd); check("R1 ctrl in reset", rd, 0);
        bus_read(A_PEND, rd); check("R1 pend in reset", rd, 0);
        bus_read(A_EN, rd);   check("R1 en in reset", rd, 0);
        @(negedge clk); rst = 1'b0;

        // Bring-up: enable 0, discard stale event
        wait_cyc(6);
        bus_write(A_EN, 0);
        bus_write(A_PEND, 1);
        wait_cyc(2);
        bus_read(A_PEND, rd); check("R5 bring-up clear", rd, 0);

        // R2: only trigger bits stored
        bus_write(A_CTRL, 32'hFFFF_FFFE);
        bus_read(A_CTRL, rd); check("R2 ctrl upper bits read 0", rd, 2);
        bus_write(A_CTRL, 32'h0000_0001);
        bus_read(A_CTRL, rd); check("R2 ctrl code falling", rd, 1);

        // R4: falling mode, rising edge ignored then falling edge sets
        line = 1'b0; wait_cyc(6);
        bus_write(A_PEND, 1); wait_cyc(2);
        line = 1'b1; wait_cyc(6);
        bus_read(A_PEND, rd); check("R4 opposite edge ignored", rd, 0);
        line = 1'b0; wait_cyc(6);
        bus_read(A_PEND, rd); check("R4 falling edge sets", rd, 1);

        // R5: write of 0 has no effect, write of 1 clears
        bus_write(A_PEND, 0); wait_cyc(1);
        bus_read(A_PEND, rd); check("R5 write zero no effect", rd, 1);
        bus_write(A_PEND, 1); wait_cyc(1);
        bus_read(A_PEND, rd); check("R5 write one clears", rd, 0);

        // R3: level high cannot be cleared while active
        bus_write(A_CTRL, 2);
        line = 1'b1; wait_cyc(6);
        bus_read(A_PEND, rd); check("R3 level high sets", rd, 1);
        bus_write(A_PEND, 1); wait_cyc(1);
        bus_read(A_PEND, rd); check("R3 clear while active", rd, 1);
        line = 1'b0; wait_cyc(6);
        bus_write(A_PEND, 1); wait_cyc(1);
        bus_read(A_PEND, rd); check("R3 clear after release", rd, 0);

        // R3: level low
        bus_write(A_CTRL, 0); wait_cyc(6);
        bus_read(A_PEND, rd); check("R3 level low sets", rd, 1);
        line = 1'b1; wait_cyc(6);
        bus_write(A_PEND, 1); wait_cyc(1);
        bus_read(A_PEND, rd); check("R3 level low cleared", rd, 0);

        // R7: masking and unmasking
        bus_write(A_CTRL, 3);
        line = 1'b0; wait_cyc(6);
        line = 1'b1; wait_cyc(6);
        check("R7 masked irq low", {31'd0, irq}, 0);
        bus_read(A_PEND, rd); check("R7 pending kept while masked", rd, 1);
        bus_write(A_EN, 1); wait_cyc(2);
        check("R7 unmasked irq high", {31'd0, irq}, 1);
        bus_write(A_EN, 0); wait_cyc(2);
        check("R7 remasked irq low", {31'd0, irq}, 0);
        bus_write(A_EN, 1);

        // R8: exact latency, rising mode, enable 1, pending 0
        line = 1'b0; wait_cyc(6);
        bus_write(A_PEND, 1); wait_cyc(2);
        check("R8 irq low before edge", {31'd0, irq}, 0);
        @(negedge clk); line = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); check("R8 irq low after third edge", {31'd0, irq}, 0);
        @(posedge clk);
        @(negedge clk); check("R8 irq high after fourth edge", {31'd0, irq}, 1);

        // R9: set and clear in the same cycle; pending already 1
        line = 1'b0; wait_cyc(6);
        @(negedge clk); line = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = A_PEND; wdata = 1;
        @(negedge clk); sel = 1'b0; wr = 1'b0; wdata = 0;
        bus_read(A_PEND, rd); check("R9 set wins over clear", rd, 1);

        // R6, R10: other offsets
        bus_write(A_ALT, 0); wait_cyc(1);
        bus_read(A_EN, rd); check("R6 enable at 0x08 not 0x34", rd, 1);
        bus_read(A_ALT, rd); check("R10 unused 0x34 reads 0", rd, 0);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, rd); check("R10 unused 0x10 reads 0", rd, 0);
        bus_read(A_CTRL, rd); check("R10 ctrl untouched", rd, 3);
        @(negedge clk); sel = 1'b0; addr = A_CTRL; #2;
        check("R10 idle rdata 0", rdata, 0);

        // Random phase against a model
        bus_write(A_CTRL, 0); bus_write(A_EN, 0);
        line = 1'b1; wait_cyc(6);
        bus_write(A_PEND, 1); wait_cyc(6);
        m_mode = 0; m_en = 0; m_line = 1; m_pend = 0;
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: begin
                    m_mode = $urandom_range(0, 3);
                    bus_write(A_CTRL, m_mode);
                end
                1: begin
                    m_en = 1'($urandom_range(0, 1));
                    bus_write(A_EN, {31'd0, m_en});
                end
                2: begin
                    bit nl;
                    nl = 1'($urandom_range(0, 1));
                    if (edge_hit(m_mode, m_line, nl)) m_pend = 1'b1;
                    m_line = nl;
                    @(negedge clk); line = nl;
                end
                default: begin
                    bus_write(A_PEND, 1);
                    m_pend = 1'b0;
                end
            endcase
            if (lvl_active(m_mode, m_line)) m_pend = 1'b1;
            wait_cyc(6);
            bus_read(A_PEND, rd);
            check("R3/R4 random pending", rd, {31'd0, m_pend});
            check("R7 random irq", {31'd0, irq}, {31'd0, m_pend & m_en});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule